// File: doc/BRIEF.md
# Interleaved Four-Bank Register File with Partner Access

This block is the general-purpose register store of a wide-issue core: 64 registers of 64 bits, spread over four banks of 16 entries. The two low bits of a register number pick the bank and the upper four bits pick the entry inside that bank. Three read ports serve three independent source operands per cycle. Two write ports let two results retire in one cycle, for example a fast load result and a slower address-update result coming from the same instruction.

Every read port has a partner mode. With it set, the port returns register n in the low 64 bits and its partner, register n with bit 0 inverted, in the high 64 bits. No adder is needed to find the partner. A register and its partner always sit in two different banks, so the two write ports can also store a pair in a single cycle.

Reads are registered: data for the addresses applied in one cycle appears after the next rising edge. Write port 0 is a sink that always accepts. Write port 1 follows valid/ready rules. Its ready signal depends only on port 0's valid and bank and on port 1's address, never on port 1's own valid. When ready is low while valid is high, port 1's write is not performed, and the issue logic must keep the same address, data and enables on the port and present them again. The conflict output flags that cycle.

Top module: `rf_banked_pair`

## Requirements
- R1: After reset every one of the 64 registers reads as zero on every read port.
- R2: Register number a maps to bank a[1:0] and entry a[5:2]. All 64 registers hold distinct values independently.
- R3: Read addresses applied in cycle t produce data on `rd_data` after the rising edge that ends cycle t, and the data stays there until the next edge. Read port p uses `rd_addr[6p+5:6p]` and drives `rd_data[128p+127:128p]`.
- R4: The low 64 bits of a read port carry register a. The high 64 bits carry register a XOR 1 when that port's `rd_pair` bit was set, and zero otherwise.
- R5: When both write ports are valid and their addresses differ in bits [1:0], both writes land in the same cycle, and `wr1_ready` is high.
- R6: When both write ports are valid and their addresses share bits [1:0], only write port 0 lands. `wr1_ready` is low and `wr_conflict` is high in that cycle, and the register named by port 1 keeps its old value.
- R7: When both write ports name the same register, port 0's data is stored and `wr_conflict` is high.
- R8: Write-enable bit i (bit 0 = bits [7:0]) updates byte i of the addressed register. Bytes whose enable is low keep their value, and unaddressed registers keep theirs.
- R9: A read of a register that is written in the same cycle returns the value after the write, including the merge of the bytes a partial write did not touch.
- R10: The three read ports return three unrelated registers in the same cycle.
- R11: Port 1 addressing the partner (port 0 address XOR 1) never raises `wr_conflict`, so a pair is written in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears all registers and read outputs |
| wr0_valid | input | 1 | Write port 0 request (always accepted) |
| wr0_addr | input | 6 | Write port 0 register number |
| wr0_data | input | 64 | Write port 0 data |
| wr0_be | input | 8 | Write port 0 byte enables |
| wr1_valid | input | 1 | Write port 1 request |
| wr1_ready | output | 1 | Write port 1 accepted this cycle when high |
| wr1_addr | input | 6 | Write port 1 register number |
| wr1_data | input | 64 | Write port 1 data |
| wr1_be | input | 8 | Write port 1 byte enables |
| wr_conflict | output | 1 | Both ports valid on one bank; port 1 must replay |
| rd_addr | input | 18 | Three packed 6-bit read addresses |
| rd_pair | input | 3 | Per-port partner mode |
| rd_data | output | 384 | Three packed 128-bit read results |

## Verification
A bank-steering fault stores a value in the wrong bank or entry. Partner reads and full sweeps of all 64 registers show such a fault within one read cycle of the faulty write. A wrong conflict decision shows at once on `wr_conflict` and `wr1_ready` in the same cycle. A lost or misplaced write to the victim register shows one cycle later, when that register is read back. A broken byte merge or bypass shows on the very read issued in the write cycle, because the expected value is the merged one.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DW         = 64;
  parameter int unsigned RF_BANK_BITS  = 2;
  parameter int unsigned RF_ENTRY_BITS = 4;

  localparam int unsigned RF_AW    = RF_BANK_BITS + RF_ENTRY_BITS;
  localparam int unsigned RF_BYTES = RF_DW / 8;
  localparam int unsigned RF_BANKS = 1 << RF_BANK_BITS;
  localparam int unsigned RF_DEPTH = 1 << RF_ENTRY_BITS;

  typedef struct packed {
    logic                     en;
    logic [RF_ENTRY_BITS-1:0] entry;
    logic [RF_DW-1:0]         data;
    logic [RF_BYTES-1:0]      be;
  } bank_wr_t;

  function automatic logic [RF_DW-1:0] byte_merge(input logic [RF_DW-1:0] old_v,
                                                  input logic [RF_DW-1:0] new_v,
                                                  input logic [RF_BYTES-1:0] be);
    logic [RF_DW-1:0] res;
    res = old_v;
    for (int i = 0; i < int'(RF_BYTES); i++) begin
      if (be[i]) res[8*i +: 8] = new_v[8*i +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/rf_wr_steer.sv
module rf_wr_steer
  import rf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v0,
  input  logic [RF_AW-1:0]         a0,
  input  logic [RF_DW-1:0]         d0,
  input  logic [RF_BYTES-1:0]      be0,
  input  logic                     v1,
  input  logic [RF_AW-1:0]         a1,
  input  logic [RF_DW-1:0]         d1,
  input  logic [RF_BYTES-1:0]      be1,
  output logic                     ready1,
  output logic                     conflict,
  output bank_wr_t [RF_BANKS-1:0]  bank_wr
);
  logic [RF_BANK_BITS-1:0] bk0, bk1;
  assign bk0 = a0[RF_BANK_BITS-1:0];
  assign bk1 = a1[RF_BANK_BITS-1:0];

  // port 0 has priority; ready of port 1 never looks at its own valid
  assign ready1   = !(v0 && (bk0 == bk1));
  assign conflict = v1 && !ready1;

  always_comb begin
    for (int b = 0; b < int'(RF_BANKS); b++) begin
      bank_wr[b] = '0;
      if (v1 && ready1 && (int'(bk1) == b)) begin
        bank_wr[b].en    = 1'b1;
        bank_wr[b].entry = a1[RF_AW-1:RF_BANK_BITS];
        bank_wr[b].data  = d1;
        bank_wr[b].be    = be1;
      end
      if (v0 && (int'(bk0) == b)) begin
        bank_wr[b].en    = 1'b1;
        bank_wr[b].entry = a0[RF_AW-1:RF_BANK_BITS];
        bank_wr[b].data  = d0;
        bank_wr[b].be    = be0;
      end
    end
  end

  assert_conflict_same_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (v0 && v1 && (a0[RF_BANK_BITS-1:0] == a1[RF_BANK_BITS-1:0])));

  assert_same_reg_conflicts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && (a0 == a1)) |-> conflict);

  assert_partner_no_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && (a1 == (a0 ^ RF_AW'(1)))) |-> (!conflict && ready1));
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int unsigned NSLOT = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  bank_wr_t                             wr,
  input  logic [NSLOT-1:0][RF_ENTRY_BITS-1:0]  rd_entry,
  output logic [NSLOT-1:0][RF_DW-1:0]          rd_val
);
  logic [RF_DW-1:0] mem [RF_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < int'(RF_DEPTH); e++) mem[e] <= '0;
    end else if (wr.en) begin
      mem[wr.entry] <= byte_merge(mem[wr.entry], wr.data, wr.be);
    end
  end

  // write-first view: a read of the entry being written sees the merged value
  always_comb begin
    for (int s = 0; s < int'(NSLOT); s++) begin
      if (wr.en && (wr.entry == rd_entry[s]))
        rd_val[s] = byte_merge(mem[rd_entry[s]], wr.data, wr.be);
      else
        rd_val[s] = mem[rd_entry[s]];
    end
  end

  for (genvar e = 0; e < int'(RF_DEPTH); e++) begin : g_hold
    assert_idle_entry_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr.en && (wr.entry == RF_ENTRY_BITS'(e))) |=> (mem[e] == $past(mem[e])));
  end

  assert_full_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && (&wr.be)) |=> (mem[$past(wr.entry)] == $past(wr.data)));
endmodule

// File: rtl/rf_banked_pair.sv
module rf_banked_pair
  import rf_pkg::*;
#(
  parameter int unsigned NUM_RD = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr0_valid,
  input  logic [RF_AW-1:0]            wr0_addr,
  input  logic [RF_DW-1:0]            wr0_data,
  input  logic [RF_BYTES-1:0]         wr0_be,
  input  logic                        wr1_valid,
  output logic                        wr1_ready,
  input  logic [RF_AW-1:0]            wr1_addr,
  input  logic [RF_DW-1:0]            wr1_data,
  input  logic [RF_BYTES-1:0]         wr1_be,
  output logic                        wr_conflict,
  input  logic [NUM_RD*RF_AW-1:0]     rd_addr,
  input  logic [NUM_RD-1:0]           rd_pair,
  output logic [NUM_RD*2*RF_DW-1:0]   rd_data
);
  localparam int unsigned NSLOT = 2 * NUM_RD;

  bank_wr_t [RF_BANKS-1:0]                       bank_wr;
  logic [NSLOT-1:0][RF_AW-1:0]                   slot_addr;
  logic [NSLOT-1:0][RF_ENTRY_BITS-1:0]           slot_entry;
  logic [RF_BANKS-1:0][NSLOT-1:0][RF_DW-1:0]     bank_rd;
  logic [NSLOT-1:0][RF_DW-1:0]                   slot_val;
  logic                                          started;

  rf_wr_steer u_steer (
    .clk(clk), .rst_n(rst_n),
    .v0(wr0_valid), .a0(wr0_addr), .d0(wr0_data), .be0(wr0_be),
    .v1(wr1_valid), .a1(wr1_addr), .d1(wr1_data), .be1(wr1_be),
    .ready1(wr1_ready), .conflict(wr_conflict), .bank_wr(bank_wr)
  );

  // slot 2p reads register a, slot 2p+1 reads its partner a^1
  for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
    assign slot_addr[s]  = rd_addr[(s/2)*RF_AW +: RF_AW] ^ RF_AW'(s % 2);
    assign slot_entry[s] = slot_addr[s][RF_AW-1:RF_BANK_BITS];
    assign slot_val[s]   = bank_rd[slot_addr[s][RF_BANK_BITS-1:0]][s];
  end

  for (genvar b = 0; b < int'(RF_BANKS); b++) begin : g_bank
    rf_bank #(.NSLOT(NSLOT)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(bank_wr[b]),
      .rd_entry(slot_entry), .rd_val(bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      for (int p = 0; p < int'(NUM_RD); p++) begin
        rd_data[p*2*RF_DW +: RF_DW]         <= slot_val[2*p];
        rd_data[p*2*RF_DW + RF_DW +: RF_DW] <= rd_pair[p] ? slot_val[2*p+1] : '0;
      end
    end
  end

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_chk
    assert_single_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(rd_pair[p])) |-> (rd_data[p*2*RF_DW + RF_DW +: RF_DW] == '0));
  end
endmodule

// File: tb/rf_banked_pair_tb.sv
module rf_banked_pair_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr0_valid = 0, wr1_valid = 0;
  logic [5:0]  wr0_addr = 0, wr1_addr = 0;
  logic [63:0] wr0_data = 0, wr1_data = 0;
  logic [7:0]  wr0_be = 0, wr1_be = 0;
  logic        wr1_ready, wr_conflict;
  logic [17:0] rd_addr = 0;
  logic [2:0]  rd_pair = 0;
  logic [383:0] rd_data;

  rf_banked_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr0_valid(wr0_valid), .wr0_addr(wr0_addr), .wr0_data(wr0_data), .wr0_be(wr0_be),
    .wr1_valid(wr1_valid), .wr1_ready(wr1_ready), .wr1_addr(wr1_addr),
    .wr1_data(wr1_data), .wr1_be(wr1_be), .wr_conflict(wr_conflict),
    .rd_addr(rd_addr), .rd_pair(rd_pair), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] ref_m [64];
  logic [383:0] exp_q [$];
  string tag_q [$];

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                        input logic [7:0] be);
    logic [63:0] r;
    r = o;
    for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  task automatic cyc(input logic v0, input logic [5:0] a0, input logic [63:0] d0,
                     input logic [7:0] b0, input logic v1, input logic [5:0] a1,
                     input logic [63:0] d1, input logic [7:0] b1,
                     input logic [17:0] ra, input logic [2:0] rp, input string tag);
    logic same_bank, exp_rdy, exp_cf;
    logic [383:0] e;
    @(negedge clk);
    wr0_valid = v0; wr0_addr = a0; wr0_data = d0; wr0_be = b0;
    wr1_valid = v1; wr1_addr = a1; wr1_data = d1; wr1_be = b1;
    rd_addr = ra; rd_pair = rp;
    same_bank = (a0[1:0] == a1[1:0]);
    exp_rdy = !(v0 && same_bank);
    exp_cf  = v1 && v0 && same_bank;
    #1;
    checks++;
    if (wr1_ready !== exp_rdy || wr_conflict !== exp_cf) begin
      errors++;
      $display("FAIL %s handshake: ready=%b conflict=%b expected ready=%b conflict=%b",
               tag, wr1_ready, wr_conflict, exp_rdy, exp_cf);
    end
    if (v1 && exp_rdy) ref_m[a1] = merge(ref_m[a1], d1, b1);
    if (v0) ref_m[a0] = merge(ref_m[a0], d0, b0);
    for (int p = 0; p < 3; p++) begin
      e[p*128 +: 64]      = ref_m[ra[6*p +: 6]];
      e[p*128 + 64 +: 64] = rp[p] ? ref_m[ra[6*p +: 6] ^ 6'd1] : 64'd0;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wr0_valid = 0; wr1_valid = 0;
  endtask

  task automatic rd3(input logic [5:0] x, input logic [5:0] y, input logic [5:0] z,
                     input logic [2:0] rp, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, {z, y, x}, rp, tag);
  endtask

  // monitor: pop one expected item per completed read cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [383:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int p = 0; p < 3; p++) begin
          checks++;
          if (rd_data[p*128 +: 128] !== e[p*128 +: 128]) begin
            errors++;
            $display("FAIL %s R3 port%0d: got %h expected %h", t, p,
                     rd_data[p*128 +: 128], e[p*128 +: 128]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_m[i] = 64'd0;
    repeat (3) @(negedge clk);
    // R1: reset value observed before any release edge
    checks++;
    if (rd_data !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %h expected 0", rd_data);
    end
    rst_n = 1'b1;
    rd3(6'd0, 6'd33, 6'd63, 3'b111, "R1 reset contents");

    // R2 R5 R11: fill all 64 registers with pair writes (n, n^1)
    for (int n = 0; n < 64; n += 2)
      cyc(1, 6'(n), {32'hA5A50000, 32'(n)} ^ 64'h1111, 8'hFF,
          1, 6'(n + 1), {32'h5A5A0000, 32'(n + 1)}, 8'hFF,
          {6'(n), 6'(n ^ 1), 6'(63 - n)}, 3'b101, "R11 pair write");
    for (int n = 0; n < 64; n += 3)
      rd3(6'(n), 6'((n + 17) % 64), 6'((n + 42) % 64), 3'b010, "R2 sweep");

    // R4 R10: mixed partner modes on three unrelated registers
    rd3(6'd7, 6'd20, 6'd45, 3'b001, "R4 partner lo");
    rd3(6'd6, 6'd21, 6'd44, 3'b110, "R10 three reads");

    // R6: same bank, different registers (4 and 8 both bank 0)
    cyc(1, 6'd4, 64'hDEAD_0004, 8'hFF, 1, 6'd8, 64'hBEEF_0008, 8'hFF,
        {6'd8, 6'd4, 6'd8}, 3'b000, "R6 collision");
    rd3(6'd8, 6'd4, 6'd9, 3'b001, "R6 victim unchanged");
    cyc(0, 0, 0, 0, 1, 6'd8, 64'hBEEF_0008, 8'hFF, {6'd8, 6'd8, 6'd8}, 3'b000, "R6 replay");
    // R6: port1 not valid still sees ready low on shared bank
    cyc(1, 6'd13, 64'h13, 8'hFF, 0, 6'd1, 64'h0, 8'h00, {6'd13, 6'd1, 6'd0}, 3'b000, "R6 ready");

    // R7: identical register, port 0 wins
    cyc(1, 6'd20, 64'h0000_0000_0000_0A0A, 8'hFF, 1, 6'd20, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF,
        {6'd20, 6'd21, 6'd20}, 3'b010, "R7 same reg");

    // R8: partial writes, then read back
    cyc(1, 6'd5, 64'h0123_4567_89AB_CDEF, 8'hFF, 0, 0, 0, 0, 18'd0, 3'b000, "R8 setup");
    cyc(1, 6'd5, 64'hFFEE_DDCC_BBAA_9988, 8'hA5, 1, 6'd6, 64'h7777_7777_7777_7777, 8'h00,
        18'd0, 3'b000, "R8 masked");
    rd3(6'd5, 6'd6, 6'd4, 3'b011, "R8 readback");

    // R9: bypass of a partial write to a register read the same cycle
    cyc(1, 6'd9, 64'hCAFE_F00D_1234_5678, 8'h0F, 1, 6'd10, 64'h1010_1010_1010_1010, 8'hF0,
        {6'd11, 6'd10, 6'd9}, 3'b111, "R9 bypass");

    // random traffic against the reference array
    for (int k = 0; k < 400; k++)
      cyc(1'($urandom), 6'($urandom), {$urandom, $urandom}, 8'($urandom),
          1'($urandom), 6'($urandom), {$urandom, $urandom}, 8'($urandom),
          18'($urandom), 3'($urandom), "R5 random");

    rd3(6'd0, 6'd1, 6'd2, 3'b111, "R2 final");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule